// File: doc/BRIEF.md
# Ratio-Selectable Data Word Demultiplexer

This block takes a stream of converter samples on a fast clock and spreads consecutive words across four output ports, named A, B, C and D. Each sample is a data word plus one extra flag bit that marks an out-of-range condition. A ratio input selects two-way spreading, where words alternate between A and B and ports C and D stay idle, or four-way spreading, where words rotate through A, B, C and D. Each port therefore refreshes at half or a quarter of the input word rate.

In the default (aligned) mode, words are collected in staging registers. When the last word of a group arrives, all ports are loaded together and a shared valid strobe pulses for one cycle. Each port's extra output then carries the flag of the word it holds. In staggered mode each port is loaded the moment its own word arrives, so the port updates are offset by one word period. Each port's extra output stops carrying the flag and becomes a data-ready line that toggles on every load of that port.

Changes to the ratio and the staggered-mode select are sampled only when a word is accepted at the start of a group. A group that has started always completes in the mode it started with.

Top module: `word_demux`

## Requirements
- R1: A synchronous active-high `rst` clears all port data, all extra bits and `outValid` to 0. The first word accepted after reset is steered to port A.
- R2: In aligned two-way mode (`ratioSel`=0, `staggerSel`=0), accepted words go alternately to A (bits 9:0 of `portData`) and B (bits 19:10). Both ports load on the edge that accepts the B word, and `outValid` is 1 for the cycle that follows that edge only.
- R3: In aligned four-way mode (`ratioSel`=1), accepted words go to A, B, C (bits 29:20) and D (bits 39:30) in that order. All four ports load together, and `outValid` pulses, on the edge that accepts the D word.
- R4: While the active ratio is two-way, the data of ports C and D and their extra bits (`portExtra` bits 2 and 3) read 0.
- R5: In aligned mode, `portExtra` bit p equals the `inFlag` value that was accepted with the word now held in port p.
- R6: In staggered mode (`staggerSel`=1), a port loads on the edge that accepts its own word. Its `portExtra` bit toggles on each such load and starts from 0 after reset. `inFlag` has no effect, and `outValid` stays 0.
- R7: `ratioSel` and `staggerSel` are sampled only on an edge that accepts the first word of a group (the word for port A). Changing them in the middle of a group has no effect until that group has completed.
- R8: On an edge where `inValid` is 0, no output changes and the steering position is kept. A port keeps its data and extra bit until its next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input word clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Accept the word on this edge |
| inWord | input | DATA_W | Converter data word |
| inFlag | input | 1 | Out-of-range flag of the word |
| ratioSel | input | 1 | 0 selects two-way spreading, 1 selects four-way |
| staggerSel | input | 1 | 1 selects staggered per-port loading |
| portData | output | 4*DATA_W | Ports A..D, A in the lowest DATA_W bits |
| portExtra | output | 4 | Per-port flag bit, or data-ready toggle in staggered mode |
| outValid | output | 1 | One-cycle pulse when an aligned group is loaded |

## Verification
Every result is registered once, so any change caused by an accepting edge is visible right after that edge, and `outValid` lasts exactly one cycle. The bench drives inputs on the falling edge and samples all outputs on the next falling edge. This means each check sees the state produced by exactly one rising edge. A model written from the requirements advances once per rising edge, so expected port contents, toggles and pulses line up cycle by cycle. Checks of mid-group mode changes and idle cycles compare state both before and after the edge concerned.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
  localparam int NPORT = 4;
  localparam int SLOT_W = $clog2(NPORT);

  typedef struct packed {
    logic [NPORT-1:0] stageWe;   // aligned mode: stage this word
    logic [NPORT-1:0] directWe;  // staggered mode: load port now
    logic             commit;    // aligned group complete
    logic             ratio4;    // active ratio is four-way
    logic             stag;      // active mode is staggered
  } wdmCtl_t;
endpackage

// File: rtl/wdm_ctrl.sv
module wdm_ctrl
  import wdm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  input  logic    ratioSel,
  input  logic    staggerSel,
  output wdmCtl_t ctl
);
  localparam logic [SLOT_W-1:0] LAST4 = SLOT_W'(NPORT - 1);
  localparam logic [SLOT_W-1:0] LAST2 = SLOT_W'(NPORT / 2 - 1);

  logic [SLOT_W-1:0] slot;
  logic              ratioAct, stagAct;
  logic              groupStart, effRatio, effStag, atLast;
  logic [NPORT-1:0]  slotHot;

  assign groupStart = (slot == '0);
  assign effRatio   = groupStart ? ratioSel : ratioAct;
  assign effStag    = groupStart ? staggerSel : stagAct;
  assign atLast     = (slot == (effRatio ? LAST4 : LAST2));
  assign slotHot    = NPORT'(1) << slot;

  always_comb begin
    ctl.stageWe  = (inValid && !effStag) ? slotHot : '0;
    ctl.directWe = (inValid && effStag) ? slotHot : '0;
    ctl.commit   = inValid && !effStag && atLast;
    ctl.ratio4   = ratioAct;
    ctl.stag     = stagAct;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot     <= '0;
      ratioAct <= 1'b0;
      stagAct  <= 1'b0;
    end else if (inValid) begin
      slot <= atLast ? '0 : slot + 1'b1;
      if (groupStart) begin
        ratioAct <= ratioSel;
        stagAct  <= staggerSel;
      end
    end
  end
endmodule

// File: rtl/wdm_path.sv
module wdm_path
  import wdm_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  wdmCtl_t                 ctl,
  input  logic [DATA_W-1:0]       inWord,
  input  logic                    inFlag,
  output logic [NPORT*DATA_W-1:0] portData,
  output logic [NPORT-1:0]        portExtra,
  output logic                    outValid
);
  logic [DATA_W-1:0] stageWord [NPORT];
  logic [DATA_W-1:0] outWord   [NPORT];
  logic [NPORT-1:0]  stageFlag, outFlag, readyTgl;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NPORT; p++) begin
        stageWord[p] <= '0;
        outWord[p]   <= '0;
      end
      stageFlag <= '0;
      outFlag   <= '0;
      readyTgl  <= '0;
      outValid  <= 1'b0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (ctl.stageWe[p]) begin
          stageWord[p] <= inWord;
          stageFlag[p] <= inFlag;
        end
        if (ctl.commit) begin
          outWord[p] <= ctl.stageWe[p] ? inWord : stageWord[p];
          outFlag[p] <= ctl.stageWe[p] ? inFlag : stageFlag[p];
        end
        if (ctl.directWe[p]) begin
          outWord[p]  <= inWord;
          readyTgl[p] <= ~readyTgl[p];
        end
      end
      outValid <= ctl.commit;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic extraSel;
    assign extraSel = ctl.stag ? readyTgl[p] : outFlag[p];
    if (p < NPORT / 2) begin : g_always
      assign portData[p*DATA_W +: DATA_W] = outWord[p];
      assign portExtra[p] = extraSel;
    end else begin : g_upper
      assign portData[p*DATA_W +: DATA_W] = ctl.ratio4 ? outWord[p] : '0;
      assign portExtra[p] = ctl.ratio4 & extraSel;
    end
  end
endmodule

// File: rtl/word_demux.sv
module word_demux
  import wdm_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic [DATA_W-1:0]       inWord,
  input  logic                    inFlag,
  input  logic                    ratioSel,
  input  logic                    staggerSel,
  output logic [NPORT*DATA_W-1:0] portData,
  output logic [NPORT-1:0]        portExtra,
  output logic                    outValid
);
  wdmCtl_t ctlBus;

  wdm_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid),
    .ratioSel(ratioSel), .staggerSel(staggerSel), .ctl(ctlBus)
  );

  wdm_path #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .rst(rst), .ctl(ctlBus), .inWord(inWord), .inFlag(inFlag),
    .portData(portData), .portExtra(portExtra), .outValid(outValid)
  );
endmodule

// File: rtl/wdm_chk.sv
module wdm_chk
  import wdm_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    inValid,
  input logic [NPORT*DATA_W-1:0] portData,
  input logic [NPORT-1:0]        portExtra,
  input logic                    outValid,
  input wdmCtl_t                 ctl
);
  localparam int HALF = NPORT / 2 * DATA_W;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (portData == '0 && portExtra == '0 && !outValid));

  assert_valid_follows_accept_R2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid));

  assert_one_stage_slot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl.stageWe) && $onehot0(ctl.directWe));

  assert_upper_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !ctl.ratio4 |-> (portData[NPORT*DATA_W-1:HALF] == '0 &&
                     portExtra[NPORT-1:NPORT/2] == '0));

  assert_stag_no_valid_R6: assert property (@(posedge clk) disable iff (rst)
    ctl.stag |-> !outValid);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(portData) && $stable(portExtra)));
endmodule

bind word_demux wdm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .portData(portData),
  .portExtra(portExtra), .outValid(outValid), .ctl(ctlBus)
);

// File: tb/tb_word_demux.sv
`timescale 1ns/1ps
module tb_word_demux;
  localparam int DW = 10;
  localparam int NP = 4;

  logic clk = 1'b0, rst = 1'b1, inValid = 1'b0, inFlag = 1'b0;
  logic ratioSel = 1'b0, staggerSel = 1'b0;
  logic [DW-1:0] inWord = '0;
  logic [NP*DW-1:0] portData;
  logic [NP-1:0] portExtra;
  logic outValid;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  word_demux #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord), .inFlag(inFlag),
    .ratioSel(ratioSel), .staggerSel(staggerSel),
    .portData(portData), .portExtra(portExtra), .outValid(outValid)
  );

  // model state
  int mPos;
  bit mRatio, mStag, mValid;
  logic [DW-1:0] mStage [NP];
  logic [DW-1:0] mOut [NP];
  bit mStageF [NP];
  bit mOutF [NP];
  bit mTgl [NP];

  task automatic modelReset();
    mPos = 0; mRatio = 0; mStag = 0; mValid = 0;
    for (int p = 0; p < NP; p++) begin
      mStage[p] = '0; mOut[p] = '0; mStageF[p] = 0; mOutF[p] = 0; mTgl[p] = 0;
    end
  endtask

  task automatic modelStep(bit v, bit r, bit s, bit f, logic [DW-1:0] w);
    int groupSize;
    mValid = 0;
    if (v) begin
      if (mPos == 0) begin mRatio = r; mStag = s; end
      groupSize = mRatio ? 4 : 2;
      if (mStag) begin
        mOut[mPos] = w; mTgl[mPos] = !mTgl[mPos];
      end else begin
        mStage[mPos] = w; mStageF[mPos] = f;
        if (mPos == groupSize - 1) begin
          for (int p = 0; p < NP; p++) begin mOut[p] = mStage[p]; mOutF[p] = mStageF[p]; end
          mValid = 1;
        end
      end
      mPos = (mPos + 1) % groupSize;
    end
  endtask

  task automatic compare(string tag);
    logic [NP*DW-1:0] expD;
    logic [NP-1:0] expE;
    for (int p = 0; p < NP; p++) begin
      if (p >= 2 && !mRatio) begin
        expD[p*DW +: DW] = '0; expE[p] = 1'b0;
      end else begin
        expD[p*DW +: DW] = mOut[p]; expE[p] = mStag ? mTgl[p] : mOutF[p];
      end
    end
    checks++;
    if (portData !== expD || portExtra !== expE || outValid !== mValid) begin
      errors++;
      $display("FAIL %s data=%h extra=%b valid=%b expected data=%h extra=%b valid=%b",
               tag, portData, portExtra, outValid, expD, expE, mValid);
    end
  endtask

  // one input-word cycle: drive at falling edge, sample at next falling edge
  task automatic cyc(bit v, bit r, bit s, bit f, logic [DW-1:0] w, string tag);
    inValid = v; ratioSel = r; staggerSel = s; inFlag = f; inWord = w;
    @(posedge clk);
    modelStep(v, r, s, f, w);
    @(negedge clk);
    compare(tag);
  endtask

  // vector: {tag[3:0], valid, ratio, stag, flag, word[9:0]}
  localparam int NV = 28;
  localparam logic [17:0] VEC [NV] = '{
    {4'd2, 4'b1001, 10'h101}, {4'd2, 4'b1000, 10'h102},   // R2 two-way A,B
    {4'd5, 4'b1000, 10'h103}, {4'd5, 4'b1001, 10'h104},   // R5 flags per port
    {4'd8, 4'b0000, 10'h3FF},                             // R8 idle edge
    {4'd3, 4'b1101, 10'h201}, {4'd3, 4'b1100, 10'h202},   // R3 four-way
    {4'd3, 4'b1101, 10'h203}, {4'd3, 4'b1100, 10'h204},
    {4'd7, 4'b1100, 10'h211}, {4'd7, 4'b1000, 10'h212},   // R7 mid-group change
    {4'd7, 4'b1010, 10'h213}, {4'd7, 4'b1000, 10'h214},
    {4'd4, 4'b1000, 10'h221}, {4'd4, 4'b1000, 10'h222},   // R4 back to two-way
    {4'd6, 4'b1111, 10'h301}, {4'd6, 4'b1101, 10'h302},   // R6 staggered four-way
    {4'd8, 4'b0110, 10'h000},
    {4'd6, 4'b1101, 10'h303}, {4'd6, 4'b1100, 10'h304},
    {4'd6, 4'b1110, 10'h305}, {4'd6, 4'b1000, 10'h306},
    {4'd6, 4'b1001, 10'h307}, {4'd6, 4'b1000, 10'h308},
    {4'd5, 4'b1001, 10'h309}, {4'd5, 4'b1000, 10'h30A},   // R5 aligned again
    {4'd6, 4'b1010, 10'h311}, {4'd6, 4'b1001, 10'h312}    // R6 staggered two-way
  };

  function automatic string tagName(logic [3:0] t);
    case (t)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    modelReset();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    compare("R1");                                          // reset state

    for (int i = 0; i < NV; i++)
      cyc(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9:0],
          tagName(VEC[i][17:14]));

    // R8: several idle edges with changing inputs leave everything held
    repeat (3) cyc(1'b0, 1'b1, 1'b1, 1'b1, 10'h2AA, "R8");

    // R1: reset in the middle of a four-way group, first word lands on A
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 10'h0F1, "R1");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 10'h0F2, "R1");
    rst = 1'b1;
    @(posedge clk);
    modelReset();
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 10'h0A1, "R1");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 10'h0A2, "R1");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 10'h0A3, "R1");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 10'h0A4, "R3");
    checks++;
    if (portData[DW-1:0] !== 10'h0A1) begin
      errors++;
      $display("FAIL R1 port A=%h expected=%h", portData[DW-1:0], 10'h0A1);
    end
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 10'h000, "R2");             // valid drops after one cycle

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule